// File: doc/BRIEF.md
# Dual-Select Mode Configuration Port

This block is the mode-control front end of an eight-channel converter. It turns a handful of slow configuration pins into per-channel 8-bit configuration fields and three global control bits: output lane count, output drive strength and power-down. A mode pin picks between two ways of using the same four pins.

With the mode pin low, the pins form a write-only serial port that has two active-low selects. The system clock oversamples all pins through a two-flop synchronizer and detects serial clock edges digitally, so each serial pin level must be held for at least three system clocks. Each select reaches its own bank of four channel registers. The banks cover interleaved channel groups. Both selects also reach a shared global register. With the mode pin high, the select, serial clock and serial data pins become static straps that drive the global bits directly. The registers keep their contents while the straps are in use.

Top module: `cfg_port_top`

## Requirements
- R1: While `par_mode_i` is high, no serial activity on the select, clock or data pins changes any register. This covers channel fields and the global register.
- R2: A frame is captured MSB first, one bit on each rising edge of `sclk_i` while at least one select is low. Bit 15 is the write flag. Bits 14:8 are the register address and bits 7:0 are the data.
- R3: A frame commits only once both selects have returned high, and only if exactly 16 rising serial clock edges were seen. A frame of 15 bits or of 17 bits leaves every register unchanged.
- R4: A 16-bit frame whose write flag (bit 15) is 0 changes nothing.
- R5: Through select A (`csa_n_i`), addresses 0, 1, 2 and 3 write channels 0, 3, 4 and 7 (zero-based). Through select B (`csb_n_i`), the same addresses write channels 1, 2, 5 and 6. Channel k occupies `ch_cfg_o[8k+7:8k]`.
- R6: If both selects are low at any time during a frame, the write goes to the addressed slot in both banks.
- R7: Address 4, reached through either select, is the global register. Data bit 0 sets one-lane mode, bit 1 sets half drive current and bit 2 sets power-down. Addresses 5 to 127 change nothing.
- R8: After reset, every channel field is 0 and all three global outputs are 0. This means two lanes, full drive current and powered up.
- R9: While `par_mode_i` is high, the global outputs come from the pin levels. `csa_n_i` high gives one-lane, `sclk_i` high gives half drive and `sdi_i` high gives power-down. When the mode pin returns low, the stored global register reappears on the outputs.
- R10: All outputs come from registers. A pin change reaches the global outputs at the third rising clock edge after it. A committed write appears within six clocks after the selects rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_mode_i | input | 1 | Low: serial port; high: pins act as straps |
| csa_n_i | input | 1 | Select A (active low) / lane strap |
| csb_n_i | input | 1 | Select B (active low) |
| sclk_i | input | 1 | Serial clock / drive strap |
| sdi_i | input | 1 | Serial data / power-down strap |
| ch_cfg_o | output | 64 | Eight 8-bit channel fields, channel k at bits 8k+7:8k |
| one_lane_o | output | 1 | One-lane output mode |
| half_drive_o | output | 1 | Half output drive current |
| pwr_down_o | output | 1 | Power-down |

## Verification
Some properties are checked on every cycle. A commit follows exactly 16 shifted bits with a set write flag. No commit happens in strap mode. Registers hold their value without a write, and they clear on reset. In strap mode the global outputs track the synchronized pins one clock later. Other behaviour can only be shown by the bench scenarios: the interleaved channel mapping of each select, the dual-select broadcast, discarding of short and long frames, MSB-first ordering, and the return of stored values after strap mode ends. The bench's per-clock reference model covers these.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  // Map (bank, slot) to a zero-based channel number. Bank 0 is select A.
  function automatic int chan_of(input int bank, input int slot);
    int base;
    base = 4 * (slot / 2);
    if ((slot % 2) == 1) return base + ((bank == 0) ? 3 : 2);
    return base + ((bank == 0) ? 0 : 1);
  endfunction
endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
  parameter int W = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q_o  <= RST_VAL;
    end else begin
      meta <= d_i;
      q_o  <= meta;
    end
  end
endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          par_i,
  input  logic          csa_n_i,
  input  logic          csb_n_i,
  input  logic          sclk_i,
  input  logic          sdi_i,
  output logic          wr_stb_o,
  output logic          wr_a_o,
  output logic          wr_b_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  localparam int FRAME = 1 + AW + DW;
  localparam int CNTW  = $clog2(FRAME + 2);
  localparam logic [CNTW-1:0] CNT_FRAME = CNTW'(FRAME);
  localparam logic [CNTW-1:0] CNT_SAT   = CNTW'(FRAME + 1);

  logic [FRAME-1:0] shreg;
  logic [CNTW-1:0]  cnt;
  logic             sclk_q, sel_q, hit_a, hit_b;
  logic             sel_any, sclk_rise;

  assign sel_any   = ~par_i & (~csa_n_i | ~csb_n_i);
  assign sclk_rise = sclk_i & ~sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      cnt       <= '0;
      sclk_q    <= 1'b0;
      sel_q     <= 1'b0;
      hit_a     <= 1'b0;
      hit_b     <= 1'b0;
      wr_stb_o  <= 1'b0;
      wr_a_o    <= 1'b0;
      wr_b_o    <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      sclk_q   <= sclk_i;
      sel_q    <= sel_any;
      wr_stb_o <= 1'b0;
      if (sel_any) begin
        hit_a <= hit_a | ~csa_n_i;
        hit_b <= hit_b | ~csb_n_i;
        if (sclk_rise) begin
          shreg <= {shreg[FRAME-2:0], sdi_i};
          if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
        end
      end else begin
        if (sel_q && !par_i && cnt == CNT_FRAME && shreg[FRAME-1]) begin
          wr_stb_o  <= 1'b1;
          wr_a_o    <= hit_a;
          wr_b_o    <= hit_b;
          wr_addr_o <= shreg[FRAME-2 -: AW];
          wr_data_o <= shreg[DW-1:0];
        end
        cnt   <= '0;
        hit_a <= 1'b0;
        hit_b <= 1'b0;
      end
    end
  end

  // R3: a commit follows a frame of exactly FRAME bits
  a_r3_exact_length: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |-> $past(cnt) == CNT_FRAME);
  // R4: a commit only follows a set write flag
  a_r4_write_flag: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |-> $past(shreg[FRAME-1]));
  // R3: the bit counter never runs past its saturation value
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_SAT);
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int NSLOT = 4,
  parameter int AW    = 7,
  parameter int DW    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       data_i,
  output logic [NSLOT*DW-1:0] q_o
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) q_o[s*DW +: DW] <= '0;
      else if (we_i && addr_i == AW'(s)) q_o[s*DW +: DW] <= data_i;
    end
  end

  // R8: reset clears every slot
  a_r8_bank_reset: assert property (@(posedge clk)
    $past(rst) |-> q_o == '0);
  // R5: slots hold their value when no write was presented
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(we_i) && !$past(rst) |-> $stable(q_o));
endmodule

// File: rtl/cfg_port_top.sv
module cfg_port_top #(
  parameter int NSLOT = 4,
  parameter int AW    = 7,
  parameter int DW    = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  par_mode_i,
  input  logic                  csa_n_i,
  input  logic                  csb_n_i,
  input  logic                  sclk_i,
  input  logic                  sdi_i,
  output logic [2*NSLOT*DW-1:0] ch_cfg_o,
  output logic                  one_lane_o,
  output logic                  half_drive_o,
  output logic                  pwr_down_o
);
  import cfg_pkg::*;

  localparam int NBANK = 2;
  localparam logic [AW-1:0] GADDR = AW'(NSLOT);

  logic [4:0] pins_s;
  logic       par_s, csa_s, csb_s, sclk_s, sdi_s;
  logic       wr_stb, wr_a, wr_b;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [2:0] glob_reg;
  logic [NBANK-1:0][NSLOT*DW-1:0] bank_q;

  cfg_pin_sync #(.W(5), .RST_VAL(5'b01100)) u_sync (
    .clk(clk), .rst(rst),
    .d_i({par_mode_i, csa_n_i, csb_n_i, sclk_i, sdi_i}),
    .q_o(pins_s)
  );
  assign {par_s, csa_s, csb_s, sclk_s, sdi_s} = pins_s;

  cfg_serial_rx #(.AW(AW), .DW(DW)) u_rx (
    .clk(clk), .rst(rst), .par_i(par_s),
    .csa_n_i(csa_s), .csb_n_i(csb_s), .sclk_i(sclk_s), .sdi_i(sdi_s),
    .wr_stb_o(wr_stb), .wr_a_o(wr_a), .wr_b_o(wr_b),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    cfg_reg_bank #(.NSLOT(NSLOT), .AW(AW), .DW(DW)) u_bank (
      .clk(clk), .rst(rst),
      .we_i(wr_stb & ((b == 0) ? wr_a : wr_b)),
      .addr_i(wr_addr), .data_i(wr_data), .q_o(bank_q[b])
    );
    for (genvar s = 0; s < NSLOT; s++) begin : g_map
      localparam int CH = chan_of(b, s);
      assign ch_cfg_o[CH*DW +: DW] = bank_q[b][s*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      glob_reg     <= '0;
      one_lane_o   <= 1'b0;
      half_drive_o <= 1'b0;
      pwr_down_o   <= 1'b0;
    end else begin
      if (wr_stb && (wr_a || wr_b) && wr_addr == GADDR) glob_reg <= wr_data[2:0];
      if (par_s) {pwr_down_o, half_drive_o, one_lane_o} <= {sdi_s, sclk_s, csa_s};
      else       {pwr_down_o, half_drive_o, one_lane_o} <= glob_reg;
    end
  end

  // R1: strap mode never produces a register write
  a_r1_no_write_in_strap: assert property (@(posedge clk) disable iff (rst)
    par_s && $past(par_s) |-> !wr_stb);
  // R9: in strap mode the global outputs follow the synchronized pins
  a_r9_strap_follow: assert property (@(posedge clk) disable iff (rst)
    $past(par_s) && !$past(rst) |->
      {pwr_down_o, half_drive_o, one_lane_o} == $past({sdi_s, sclk_s, csa_s}));
  // R8: reset state of the global outputs
  a_r8_glob_reset: assert property (@(posedge clk)
    $past(rst) |-> {pwr_down_o, half_drive_o, one_lane_o} == 3'b000);
endmodule

// File: tb/tb_cfg_port_top.sv
module tb_cfg_port_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic par = 1'b0, csa = 1'b1, csb = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [63:0] ch_cfg;
  logic one_lane, half_drive, pwr_down;

  int checks = 0;
  int errors = 0;
  bit busy = 1'b1;
  bit done = 1'b0;
  logic [7:0] exp_ch [8];
  logic [2:0] exp_glob = 3'b000;
  int map_a [4] = '{0, 3, 4, 7};
  int map_b [4] = '{1, 2, 5, 6};

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_port_top dut (
    .clk(clk), .rst(rst), .par_mode_i(par), .csa_n_i(csa), .csb_n_i(csb),
    .sclk_i(sclk), .sdi_i(sdi), .ch_cfg_o(ch_cfg),
    .one_lane_o(one_lane), .half_drive_o(half_drive), .pwr_down_o(pwr_down)
  );

  function automatic logic [63:0] exp_flat();
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[k*8 +: 8] = exp_ch[k];
    return v;
  endfunction

  function automatic logic [2:0] exp_g();
    return par ? {sdi, sclk, csa} : exp_glob;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // R10: per-clock comparison against the model while no transfer is settling
  always @(negedge clk) begin
    if (!rst && !busy && !done) begin
      checks++;
      if (ch_cfg !== exp_flat() || {pwr_down, half_drive, one_lane} !== exp_g()) begin
        errors++;
        if (errors < 10)
          $display("FAIL R10 actual=%h/%b expected=%h/%b", ch_cfg,
                   {pwr_down, half_drive, one_lane}, exp_flat(), exp_g());
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input bit a_sel, input bit b_sel, input int nbits, input logic [31:0] word);
    busy = 1'b1;
    csa = ~a_sel;
    csb = ~b_sel;
    wait_clk(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = word[i];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
    csa = 1'b1;
    csb = 1'b1;
    sdi = 1'b0;
    wait_clk(8);
    if (!par && nbits == 16 && word[15]) begin
      if (word[14:8] < 4) begin
        if (a_sel) exp_ch[map_a[word[9:8]]] = word[7:0];
        if (b_sel) exp_ch[map_b[word[9:8]]] = word[7:0];
      end else if (word[14:8] == 7'd4) begin
        exp_glob = word[2:0];
      end
    end
    busy = 1'b0;
  endtask

  task automatic set_straps(input logic p, input logic a, input logic c, input logic d);
    busy = 1'b1;
    par = p; csa = a; sclk = c; sdi = d;
    wait_clk(6);
    busy = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < 8; k++) exp_ch[k] = 8'h00;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    busy = 1'b0;
    chk("R8 channels", ch_cfg, 64'h0);
    chk("R8 globals", {61'h0, pwr_down, half_drive, one_lane}, 64'h0);

    send(1, 0, 16, {1'b1, 7'd0, 8'hA5});
    chk("R2 msb-first ch0", ch_cfg[7:0], 64'hA5);
    send(1, 0, 16, {1'b1, 7'd1, 8'h3C});
    chk("R5 A slot1 -> ch3", ch_cfg[31:24], 64'h3C);
    chk("R5 ch1 untouched", ch_cfg[15:8], 64'h00);
    send(0, 1, 16, {1'b1, 7'd1, 8'h5A});
    chk("R5 B slot1 -> ch2", ch_cfg[23:16], 64'h5A);
    chk("R5 ch3 kept", ch_cfg[31:24], 64'h3C);
    send(1, 1, 16, {1'b1, 7'd3, 8'h77});
    chk("R6 both ch7", ch_cfg[63:56], 64'h77);
    chk("R6 both ch6", ch_cfg[55:48], 64'h77);

    send(1, 0, 15, {17'h0, 1'b1, 7'd2, 7'h08});
    chk("R3 15-bit discard", ch_cfg[39:32], 64'h00);
    send(1, 0, 17, {15'h0, 1'b1, 7'd2, 8'h22, 1'b1});
    chk("R3 17-bit discard", ch_cfg[39:32], 64'h00);
    send(1, 0, 16, {1'b0, 7'd2, 8'h33});
    chk("R4 no write flag", ch_cfg[39:32], 64'h00);
    send(1, 0, 16, {1'b1, 7'd2, 8'h44});
    chk("R3 exact 16 commits", ch_cfg[39:32], 64'h44);

    send(0, 1, 16, {1'b1, 7'd4, 8'h05});
    chk("R7 global write", {61'h0, pwr_down, half_drive, one_lane}, 64'h5);
    send(1, 0, 16, {1'b1, 7'd9, 8'hFF});
    chk("R7 unused addr globals", {61'h0, pwr_down, half_drive, one_lane}, 64'h5);
    chk("R7 unused addr channels", ch_cfg, exp_flat());

    set_straps(1, 1, 1, 0);
    chk("R9 straps one+half", {61'h0, pwr_down, half_drive, one_lane}, 64'h3);
    set_straps(1, 0, 0, 1);
    chk("R9 straps power-down", {61'h0, pwr_down, half_drive, one_lane}, 64'h4);
    send(1, 0, 16, {1'b1, 7'd0, 8'hEE});
    chk("R1 strap mode ignores serial", ch_cfg, exp_flat());
    chk("R1 ch0 kept", ch_cfg[7:0], 64'hA5);
    set_straps(0, 1, 0, 0);
    chk("R9 stored globals return", {61'h0, pwr_down, half_drive, one_lane}, 64'h5);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule